// File: doc/BRIEF.md
# Multidrop Serial Transceiver with Address Filtering

This block is an asynchronous serial transceiver for shared multidrop links in which every character carries one extra tag bit after its data bits. The tag tells an address character (tag 1) apart from a data character (tag 0). The transmitter frames a parallel word: a low start bit, 5 to 8 data bits sent least significant bit first, the tag bit, and then one or two high stop bits. The tag value sent with a word is taken from a polarity control input at the moment the word is written.

The receiver samples the line at sixteen times the bit rate and never stops decoding, even while it is switched off. While switched on it stores every character together with its tag. While switched off it keeps only address characters, so a station can sleep until it is addressed and drop the data meant for other stations. Stored characters wait in a four-entry first-in first-out queue whose head is always visible on the read port. A framing flag travels with each character, and a sticky flag records any accepted character that was lost because the queue was full.

Top module: `mdrop_uart`

## Requirements
- R1: The transmit line idles high. A frame is one low start bit, the data bits least significant first, one tag bit and the stop bits (high), with each bit lasting 16 ticks of the TICK_DIV clock divider.
- R2: `cfg_nbits` sets the data-bit count as 5 + code (code 0 to 3 gives 5 to 8 bits) for both directions. `cfg_two_stop` = 1 sends two stop bits, and 0 sends one.
- R3: The transmitted tag equals the value of `cfg_tag_pol` in the cycle the word was written. Later changes to `cfg_tag_pol` do not alter a word that is already held.
- R4: `tx_ready` is high after reset and whenever the holding register is empty. It is low in the cycle after an accepted write until the shifter takes the word. A write while `tx_ready` is low is ignored.
- R5: With `rx_enable` high, every received character is queued, and `rd_data` shows its data bits (zero-extended) with `rd_tag` showing its tag bit.
- R6: With `rx_enable` low, a received character whose tag is 1 is queued and `rx_ready` rises.
- R7: With `rx_enable` low, a received character whose tag is 0 is discarded: the queue contents and `rx_ready` stay unchanged.
- R8: A low level on the receive line that is high again at the middle of the start bit is rejected and queues nothing.
- R9: A low level sampled in the first stop-bit position sets `rd_ferr` for that character, which is still queued or dropped by the rules of R5 to R7.
- R10: The queue holds 4 characters. An accepted character that arrives when the queue is full and no read happens in the same cycle is dropped and sets `overrun`, which stays high until reset. A read in the same cycle frees the slot, so the character is kept.
- R11: `rx_ready` is high exactly when the queue is not empty. The characters leave in arrival order, one for each cycle with `rd_en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nbits | input | 2 | Data-bit count code, 5 + value |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_tag_pol | input | 1 | Tag value for the next written word |
| rx_enable | input | 1 | 1 keeps all characters, 0 keeps only address characters |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 8 | Transmit word |
| tx_ready | output | 1 | Transmit holding register is empty |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rd_en | input | 1 | Pop the head of the receive queue |
| rx_ready | output | 1 | Receive queue is not empty |
| rd_data | output | 8 | Data bits of the head character |
| rd_tag | output | 1 | Tag bit of the head character |
| rd_ferr | output | 1 | Framing error of the head character |
| overrun | output | 1 | Sticky flag for an accepted character lost to a full queue |

## Verification
A read pop and the push of a newly accepted character can land on the same clock edge while the queue is full. The bench fills the queue, then sends a fifth character and moves a single-cycle read pulse one clock at a time across its stop bit, so that the pulse falls before, on and after the push edge. For every offset it drains the queue and requires either four characters with `overrun` low or three with `overrun` high, always in arrival order. It also requires the outcome to switch from kept to lost only once as the offset grows, with both outcomes seen in the sweep.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int OVS    = 16;
    localparam int SUB_W  = $clog2(OVS);
    localparam int MID    = OVS / 2 - 1;
    localparam int MIN_BITS = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_TAG,
        ST_STOP
    } ser_st_e;

    typedef struct packed {
        logic              ferr;
        logic              tag;
        logic [DATA_W-1:0] data;
    } rx_word_t;
endpackage

// File: rtl/mdu_tick.sv
module mdu_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_t;

    tick_t q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (q.cnt == CW'(DIV - 1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tag_pol,
    input  logic [1:0]        nbits_code,
    input  logic              two_stop,
    output logic              txd,
    output logic              tx_ready
);
    typedef struct packed {
        logic              hold_full;
        logic [DATA_W-1:0] hold_data;
        logic              hold_tag;
        ser_st_e           st;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [DATA_W-1:0] shreg;
        logic              tag;
        logic              two;
        logic              second;
        logic              txd;
    } tx_t;

    tx_t q, d;

    always_comb begin
        d = q;
        if (!q.hold_full && wr_en) begin
            d.hold_full = 1'b1;
            d.hold_data = wr_data;
            d.hold_tag  = tag_pol;
        end
        if (q.st == ST_IDLE) begin
            if (q.hold_full) begin
                d.hold_full = 1'b0;
                d.st        = ST_START;
                d.shreg     = q.hold_data;
                d.tag       = q.hold_tag;
                d.last      = IDX_W'(nbits_code) + IDX_W'(MIN_BITS - 1);
                d.two       = two_stop;
                d.second    = 1'b0;
                d.sub       = '0;
                d.txd       = 1'b0;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            if (q.sub == SUB_W'(OVS - 1)) begin
                d.sub = '0;
                case (q.st)
                    ST_START: begin
                        d.st  = ST_DATA;
                        d.idx = '0;
                        d.txd = q.shreg[0];
                    end
                    ST_DATA: begin
                        if (q.idx == q.last) begin
                            d.st  = ST_TAG;
                            d.txd = q.tag;
                        end else begin
                            d.idx   = q.idx + 1'b1;
                            d.shreg = q.shreg >> 1;
                            d.txd   = q.shreg[1];
                        end
                    end
                    ST_TAG: begin
                        d.st  = ST_STOP;
                        d.txd = 1'b1;
                    end
                    ST_STOP: begin
                        if (q.two && !q.second) d.second = 1'b1;
                        else                    d.st     = ST_IDLE;
                    end
                    default: begin
                        d.st  = ST_IDLE;
                        d.txd = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.txd <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd      = q.txd;
    assign tx_ready = !q.hold_full;
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx
    import mdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        nbits_code,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_tag,
    output logic              done_ferr
);
    typedef struct packed {
        logic              s1;
        logic              s2;
        ser_st_e           st;
        logic [SUB_W-1:0]  sub;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              tag;
        logic              ferr;
        logic              done;
    } rx_t;

    rx_t q, d;
    logic [IDX_W-1:0] last;

    assign last = IDX_W'(nbits_code) + IDX_W'(MIN_BITS - 1);

    always_comb begin
        d      = q;
        d.s1   = rxd;
        d.s2   = q.s1;
        d.done = 1'b0;
        if (q.st == ST_IDLE) begin
            if (!q.s2) begin
                d.st  = ST_START;
                d.sub = '0;
            end
        end else if (tick) begin
            d.sub = q.sub + 1'b1;
            case (q.st)
                ST_START: begin
                    if (q.sub == SUB_W'(MID)) begin
                        d.sub = '0;
                        if (!q.s2) begin
                            d.st   = ST_DATA;
                            d.idx  = '0;
                            d.data = '0;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                ST_DATA: begin
                    if (q.sub == SUB_W'(OVS - 1)) begin
                        d.sub         = '0;
                        d.data[q.idx] = q.s2;
                        if (q.idx == last) d.st  = ST_TAG;
                        else               d.idx = q.idx + 1'b1;
                    end
                end
                ST_TAG: begin
                    if (q.sub == SUB_W'(OVS - 1)) begin
                        d.sub = '0;
                        d.tag = q.s2;
                        d.st  = ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (q.sub == SUB_W'(OVS - 1)) begin
                        d.sub  = '0;
                        d.ferr = !q.s2;
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign done      = q.done;
    assign done_data = q.data;
    assign done_tag  = q.tag;
    assign done_ferr = q.ferr;
endmodule

// File: rtl/mdu_fifo.sv
module mdu_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 10,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  pop_ok, push_ok;

    assign empty   = (q.cnt == '0);
    assign full    = (q.cnt == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);

    always_comb begin
        d = q;
        if (push_ok) begin
            d.mem[q.wp] = wdata;
            d.wp        = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (pop_ok) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart
    import mdu_pkg::*;
#(
    parameter int TICK_DIV   = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_nbits,
    input  logic              cfg_two_stop,
    input  logic              cfg_tag_pol,
    input  logic              rx_enable,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    input  logic              rd_en,
    output logic              rx_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_tag,
    output logic              rd_ferr,
    output logic              overrun
);
    localparam int ENTRY_W = $bits(rx_word_t);
    localparam int CNT_W   = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        logic ovr;
    } top_t;

    top_t q, d;

    logic              tick;
    logic              rx_done;
    logic [DATA_W-1:0] rx_data;
    logic              rx_tag;
    logic              rx_ferr;
    logic              accept;
    logic              fifo_empty;
    logic              fifo_full;
    logic [CNT_W-1:0]  fifo_cnt;
    rx_word_t          in_word;
    rx_word_t          head_word;

    mdu_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    mdu_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tag_pol   (cfg_tag_pol),
        .nbits_code(cfg_nbits),
        .two_stop  (cfg_two_stop),
        .txd       (txd),
        .tx_ready  (tx_ready)
    );

    mdu_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rxd       (rxd),
        .nbits_code(cfg_nbits),
        .done      (rx_done),
        .done_data (rx_data),
        .done_tag  (rx_tag),
        .done_ferr (rx_ferr)
    );

    assign accept       = rx_done && (rx_enable || rx_tag);
    assign in_word.ferr = rx_ferr;
    assign in_word.tag  = rx_tag;
    assign in_word.data = rx_data;

    mdu_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (accept),
        .wdata(in_word),
        .pop  (rd_en),
        .rdata(head_word),
        .empty(fifo_empty),
        .full (fifo_full),
        .count(fifo_cnt)
    );

    always_comb begin
        d = q;
        if (accept && fifo_full && !rd_en) d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_ready = !fifo_empty;
    assign rd_data  = head_word.data;
    assign rd_tag   = head_word.tag;
    assign rd_ferr  = head_word.ferr;
    assign overrun  = q.ovr;
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          tx_ready,
    input logic          rx_done,
    input logic          rx_tag,
    input logic          rx_enable,
    input logic          rd_en,
    input logic          rx_ready,
    input logic [CW-1:0] fifo_cnt,
    input logic          overrun
);
    AST_TX_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_ready) |=> !tx_ready); // R4

    AST_DATA_TAG_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !rx_tag && !rx_enable && !rd_en) |=> $stable(fifo_cnt)); // R7

    AST_ADDR_TAG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_tag && !rd_en && (fifo_cnt < CW'(DEPTH))) |=> (fifo_cnt == $past(fifo_cnt) + 1'b1)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CW'(DEPTH)); // R10

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R10

    AST_READY_MATCHES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == (fifo_cnt != '0)); // R11
endmodule

bind mdrop_uart mdu_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .tx_ready (tx_ready),
    .rx_done  (rx_done),
    .rx_tag   (rx_tag),
    .rx_enable(rx_enable),
    .rd_en    (rd_en),
    .rx_ready (rx_ready),
    .fifo_cnt (fifo_cnt),
    .overrun  (overrun)
);

// File: tb/sim_mdrop_uart.sv
module sim_mdrop_uart;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 2;
    localparam int BIT        = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_nbits = 2'd3;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_tag_pol = 1'b0;
    logic       rx_enable = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_ready;
    logic       txd;
    logic       rxd = 1'b1;
    logic       rd_en = 1'b0;
    logic       rx_ready;
    logic [7:0] rd_data;
    logic       rd_tag;
    logic       rd_ferr;
    logic       overrun;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    mdrop_uart #(.TICK_DIV(TICK_DIV), .FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_nbits(cfg_nbits), .cfg_two_stop(cfg_two_stop),
        .cfg_tag_pol(cfg_tag_pol), .rx_enable(rx_enable), .wr_en(wr_en), .wr_data(wr_data),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd), .rd_en(rd_en), .rx_ready(rx_ready),
        .rd_data(rd_data), .rd_tag(rd_tag), .rd_ferr(rd_ferr), .overrun(overrun)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rxd = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Drives one character on rxd; rd_at pulses rd_en at that clock of the first stop bit.
    task automatic send_frame(input logic [7:0] data, input int nb, input bit tag,
                              input int nstop, input bit bad_stop, input int rd_at);
        for (int b = 0; b < nb + 2 + nstop; b++) begin
            logic v;
            if (b == 0)           v = 1'b0;
            else if (b <= nb)     v = data[b-1];
            else if (b == nb + 1) v = tag;
            else                  v = 1'b1;
            for (int c = 0; c < BIT; c++) begin
                @(negedge clk);
                rxd   = v;
                if (bad_stop && b == nb + 2 && c < (BIT * 2) / 3) rxd = 1'b0;
                rd_en = (b == nb + 2) && (c == rd_at);
            end
        end
        @(negedge clk);
        rd_en = 1'b0;
        rxd   = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic read_expect(input logic [7:0] d, input bit tag, input bit ferr, input string req);
        @(negedge clk);
        chk(rx_ready == 1'b1, req, rx_ready, 1);
        chk(rd_data == d, req, rd_data, d);
        chk(rd_tag == tag, req, rd_tag, tag);
        chk(rd_ferr == ferr, req, rd_ferr, ferr);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] v);
        @(negedge clk);
        wr_data = v;
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic tx_expect(input logic [7:0] data, input int nb, input bit tag,
                             input int nstop, input string req);
        int w = 0;
        while (txd !== 1'b0 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        repeat (BIT / 2) @(negedge clk);
        chk(txd == 1'b0, {req, " start"}, txd, 0);
        for (int b = 0; b < nb; b++) begin
            repeat (BIT) @(negedge clk);
            chk(txd == data[b], {req, " data"}, txd, data[b]);
        end
        repeat (BIT) @(negedge clk);
        chk(txd == tag, {req, " tag R3"}, txd, tag);
        for (int s = 0; s < nstop; s++) begin
            repeat (BIT) @(negedge clk);
            chk(txd == 1'b1, {req, " stop"}, txd, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int  k;
        bit  seen_ovr;
        int  n_keep;
        int  n_lost;
        k = 0;
        seen_ovr = 1'b0;
        n_keep = 0;
        n_lost = 0;

        do_reset();
        // Reset state: R1 idle line, R4 ready, R11 empty queue, R10 flag clear
        chk(txd == 1'b1, "R1 reset txd", txd, 1);
        chk(tx_ready == 1'b1, "R4 reset tx_ready", tx_ready, 1);
        chk(rx_ready == 1'b0, "R11 reset rx_ready", rx_ready, 0);
        chk(overrun == 1'b0, "R10 reset overrun", overrun, 0);

        // Receive sweep over R2 widths and stops, tags and enable: R5, R6, R7
        for (int code = 0; code < 4; code++) begin
            for (int st = 1; st <= 2; st++) begin
                for (int tg = 0; tg < 2; tg++) begin
                    for (int en = 0; en < 2; en++) begin
                        logic [7:0] pat;
                        logic [7:0] msk;
                        pat = 8'(8'h5A + k * 29);
                        msk = 8'((1 << (5 + code)) - 1);
                        k++;
                        cfg_nbits = 2'(code);
                        cfg_two_stop = (st == 2);
                        rx_enable = en[0];
                        send_frame(pat, 5 + code, tg[0], st, 1'b0, -1);
                        if (en != 0)
                            read_expect(pat & msk, tg[0], 1'b0, "R5 R2 rx stored");
                        else if (tg != 0)
                            read_expect(pat & msk, 1'b1, 1'b0, "R6 addr kept");
                        else begin
                            @(negedge clk);
                            chk(rx_ready == 1'b0, "R7 data dropped", rx_ready, 0);
                        end
                    end
                end
            end
        end

        // Transmit sweep: R1 framing, R2 widths/stops, R3 tag capture, R4 ready
        for (int code = 0; code < 4; code++) begin
            for (int st = 1; st <= 2; st++) begin
                for (int tg = 0; tg < 2; tg++) begin
                    logic [7:0] pat;
                    pat = 8'(8'hC3 ^ (k * 53));
                    k++;
                    cfg_nbits = 2'(code);
                    cfg_two_stop = (st == 2);
                    cfg_tag_pol = tg[0];
                    tx_write(pat);
                    chk(tx_ready == 1'b0, "R4 ready low after write", tx_ready, 0);
                    cfg_tag_pol = !tg[0];
                    tx_expect(pat, 5 + code, tg[0], st, "R1 R2 tx frame");
                    repeat (BIT) @(negedge clk);
                    chk(txd == 1'b1 && tx_ready == 1'b1, "R1 R4 idle after frame", {txd, tx_ready}, 3);
                end
            end
        end

        // R4: a write while the holding register is full is ignored
        cfg_nbits = 2'd3;
        cfg_two_stop = 1'b0;
        cfg_tag_pol = 1'b1;
        tx_write(8'h96);
        tx_write(8'h3C);
        chk(tx_ready == 1'b0, "R4 hold full", tx_ready, 0);
        tx_write(8'hFF);
        tx_expect(8'h96, 8, 1'b1, 1, "R4 first word");
        tx_expect(8'h3C, 8, 1'b1, 1, "R4 second word");
        begin
            bit quiet;
            quiet = 1'b1;
            repeat (3 * BIT) begin
                @(negedge clk);
                if (txd != 1'b1) quiet = 1'b0;
            end
            chk(quiet, "R4 ignored write not sent", quiet, 1);
        end

        // R8: short low pulses are rejected
        rx_enable = 1'b1;
        @(negedge clk); rxd = 1'b0;
        repeat (6) @(negedge clk); rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rx_ready == 1'b0, "R8 glitch 6 clocks", rx_ready, 0);
        @(negedge clk); rxd = 1'b0;
        repeat (10) @(negedge clk); rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rx_ready == 1'b0, "R8 glitch 10 clocks", rx_ready, 0);
        send_frame(8'hE7, 8, 1'b0, 1, 1'b0, -1);
        read_expect(8'hE7, 1'b0, 1'b0, "R8 valid after glitch");

        // R9: framing error flagged and filtered like any other character
        rx_enable = 1'b1;
        send_frame(8'hC3, 8, 1'b0, 1, 1'b1, -1);
        read_expect(8'hC3, 1'b0, 1'b1, "R9 ferr enabled");
        rx_enable = 1'b0;
        send_frame(8'h11, 8, 1'b0, 1, 1'b1, -1);
        @(negedge clk);
        chk(rx_ready == 1'b0, "R9 ferr data dropped", rx_ready, 0);
        send_frame(8'h22, 8, 1'b1, 1, 1'b1, -1);
        read_expect(8'h22, 1'b1, 1'b1, "R9 ferr addr kept");

        // R10, R11: overflow, sticky flag and order
        rx_enable = 1'b1;
        for (int i = 0; i < 5; i++) send_frame(8'(8'h40 + i), 8, i[0], 1, 1'b0, -1);
        chk(overrun == 1'b1, "R10 overrun set", overrun, 1);
        for (int i = 0; i < 4; i++) read_expect(8'(8'h40 + i), i[0], 1'b0, "R11 order");
        @(negedge clk);
        chk(rx_ready == 1'b0, "R11 empty after drain", rx_ready, 0);
        chk(overrun == 1'b1, "R10 overrun sticky", overrun, 1);
        send_frame(8'h77, 8, 1'b0, 1, 1'b0, -1);
        read_expect(8'h77, 1'b0, 1'b0, "R10 store after overrun");
        chk(overrun == 1'b1, "R10 still sticky", overrun, 1);

        // R10: read pulse swept across the push edge of a fifth character
        for (int off = 6; off < 30; off++) begin
            do_reset();
            rx_enable = 1'b1;
            cfg_nbits = 2'd3;
            cfg_two_stop = 1'b0;
            for (int i = 0; i < 4; i++) send_frame(8'(8'h80 + i), 8, i[0], 1, 1'b0, -1);
            send_frame(8'h84, 8, 1'b0, 1, 1'b0, off);
            if (overrun == 1'b0) begin
                n_keep++;
                chk(!seen_ovr, "R10 outcome monotonic", off, 0);
                for (int i = 1; i < 5; i++) read_expect(8'(8'h80 + i), i[0], 1'b0, "R10 kept");
            end else begin
                n_lost++;
                seen_ovr = 1'b1;
                for (int i = 1; i < 4; i++) read_expect(8'(8'h80 + i), i[0], 1'b0, "R10 lost");
            end
            @(negedge clk);
            chk(rx_ready == 1'b0, "R11 drained", rx_ready, 0);
        end
        chk(n_keep > 0, "R10 some offsets keep", n_keep, 1);
        chk(n_lost > 0, "R10 some offsets lose", n_lost, 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule